// File: doc/BRIEF.md
# Link Speed Target Selector

This block chooses the signaling rate that a serial link port should train to. It looks at the rates the local port supports and the rates the link partner advertises. Three separate limits then apply: a software cap, a hardware reliability limit and a power-management downshift request. The result is the lowest of these limits. A disable bit blocks autonomous, power-driven downshifts. The reliability limit still applies when that bit is set.

The selected rate is held in a register. A single-cycle retrain request is raised in the same cycle that the registered selection takes a new value, so the training logic knows it must renegotiate. A separate compliance flag forces compliance mode at the rate software programmed. The compliance speed sits beside the normal selection and does not disturb it.

Top module: `link_speed_sel`

## Requirements
- R1: Rate codes are one-hot. Bit 0 (code 2'b01) is 2.5 GT/s and bit 1 (code 2'b10) is 5 GT/s. The supported-rate inputs use the same bit positions. With no limit active, the selection is the highest rate set in both `local_speeds` and `partner_speeds`.
- R2: When the two ends have no rate in common, or only 2.5 GT/s in common, the selection is 2'b01.
- R3: `sw_target` is an upper bound. A value of 2'b01 caps the selection at 2.5 GT/s. A value of 2'b00 falls back to 2.5 GT/s. Values 2'b10 and 2'b11 both mean 5 GT/s.
- R4: `hw_limit` = 2'b01 caps the selection at 2.5 GT/s. `hw_limit` = 2'b00 applies no restriction. Values 2'b10 and 2'b11 mean a 5 GT/s limit.
- R5: `pm_down_req` high with `auto_disable` low forces the selection to 2.5 GT/s.
- R6: With `auto_disable` high, `pm_down_req` has no effect on the selection, and `hw_limit` is still honored.
- R7: `sel_speed` is registered. It reflects the inputs present at the previous rising clock edge. A synchronous active-low reset sets it to 2'b01.
- R8: `retrain_req` is high for exactly the one cycle in which `sel_speed` takes a value different from its previous one. It is low at all other times, including after reset.
- R9: `compliance_active` follows `enter_compliance` one cycle later. `compliance_speed` is the sanitized `sw_target` (the same mapping as R3), also one cycle later. Reset clears the flag and sets the speed to 2'b01.
- R10: `sel_speed` always carries exactly one set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| local_speeds | input | 2 | Rates this port supports (bit0 2.5, bit1 5 GT/s) |
| partner_speeds | input | 2 | Rates the link partner advertises |
| sw_target | input | 2 | Software target-rate cap |
| hw_limit | input | 2 | Reliability limit, 2'b00 means none |
| pm_down_req | input | 1 | Power-management downshift request |
| auto_disable | input | 1 | Blocks autonomous power-driven changes |
| enter_compliance | input | 1 | Requests compliance mode |
| sel_speed | output | 2 | Selected rate code |
| retrain_req | output | 1 | One-cycle pulse on a selection change |
| compliance_active | output | 1 | Compliance mode flag |
| compliance_speed | output | 2 | Rate used in compliance mode |

## Verification
A wrong limit merge shows on `sel_speed` one clock after the offending input pattern is applied, because the only state on that path is the selection register. A stale copy of the previous selection inside the change detector shows as a missing or doubled `retrain_req` pulse in the same cycle as the change, or in the cycle after it. A corrupted compliance register shows on the compliance outputs one cycle after `enter_compliance` or `sw_target` moves, and the normal selection carries on unaffected.

// File: rtl/lss_pkg.sv
// Shared rate type and helper functions for the link speed selector.
// Assumes one-hot rate codes where bit i is the i-th slowest rate.
package lss_pkg;
    localparam int RATES = 2;
    typedef logic [RATES-1:0] rate_t;
    localparam rate_t SLOWEST = rate_t'(1);

    // Highest set bit as one-hot; an empty vector maps to the slowest rate.
    function automatic rate_t top_rate(rate_t v);
        rate_t r;
        r = SLOWEST;
        for (int i = 0; i < RATES; i++) begin
            if (v[i]) begin
                r = '0;
                r[i] = 1'b1;
            end
        end
        return r;
    endfunction

    // Fastest rate code the package knows.
    function automatic rate_t fastest();
        rate_t r;
        r = '0;
        r[RATES-1] = 1'b1;
        return r;
    endfunction

    // Lower of two one-hot rates (numeric order equals rate order).
    function automatic rate_t min_rate(rate_t a, rate_t b);
        return (a < b) ? a : b;
    endfunction
endpackage

// File: rtl/lss_common_cap.sv
// Finds the highest rate supported by both ends of the link.
// Assumes one-hot output; falls back to the slowest rate when nothing is shared.
module lss_common_cap
    import lss_pkg::*;
(
    input  rate_t local_vec,
    input  rate_t partner_vec,
    output rate_t common_top
);
    rate_t shared;

    // Per-rate agreement between the two ends.
    generate
        for (genvar g = 0; g < RATES; g++) begin : g_and
            assign shared[g] = local_vec[g] & partner_vec[g];
        end
    endgenerate

    // Reduce the agreement vector to its highest rate.
    always_comb common_top = top_rate(shared);
endmodule

// File: rtl/lss_limit_merge.sv
// Combines capability, software cap, reliability limit and power request.
// Assumes a zero hardware limit means "no limit"; a zero software cap means slowest.
module lss_limit_merge
    import lss_pkg::*;
(
    input  rate_t common_top,
    input  rate_t sw_target,
    input  rate_t hw_limit,
    input  logic  pm_down_req,
    input  logic  auto_disable,
    output rate_t next_sel
);
    rate_t cap_sw;
    rate_t cap_hw;
    rate_t cap_pm;

    // Sanitize the software cap into a legal rate.
    always_comb cap_sw = top_rate(sw_target);

    // Reliability limit, unrestricted when zero.
    always_comb cap_hw = (hw_limit == '0) ? fastest() : top_rate(hw_limit);

    // Power downshift only when autonomous changes are allowed.
    always_comb cap_pm = (pm_down_req && !auto_disable) ? SLOWEST : fastest();

    // Lowest of all limits wins.
    always_comb next_sel = min_rate(min_rate(common_top, cap_sw),
                                    min_rate(cap_hw, cap_pm));
endmodule

// File: rtl/lss_sel_track.sv
// Holds the selected rate and pulses a retrain request when it changes.
// Assumes next_sel is already a legal one-hot rate.
module lss_sel_track
    import lss_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  rate_t next_sel,
    output rate_t sel_q,
    output logic  retrain_q
);
    // Register the selection and flag a difference from the held value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q     <= SLOWEST;
            retrain_q <= 1'b0;
        end else begin
            sel_q     <= next_sel;
            retrain_q <= (next_sel != sel_q);
        end
    end
endmodule

// File: rtl/lss_compliance.sv
// Registers the compliance request and its rate.
// Assumes the rate uses the same sanitizing rule as the software cap.
module lss_compliance
    import lss_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  enter_req,
    input  rate_t sw_target,
    output logic  active_q,
    output rate_t speed_q
);
    // Capture the flag and the sanitized target each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            speed_q  <= SLOWEST;
        end else begin
            active_q <= enter_req;
            speed_q  <= top_rate(sw_target);
        end
    end
endmodule

// File: rtl/link_speed_sel.sv
// Top of the link speed selector: picks the training rate from capability
// and limits, raises a retrain pulse on change, and reports compliance mode.
// Assumes all control inputs are synchronous to clk.
module link_speed_sel
    import lss_pkg::*;
(
    input  logic [1:0] local_speeds,
    input  logic [1:0] partner_speeds,
    input  logic [1:0] sw_target,
    input  logic [1:0] hw_limit,
    input  logic       pm_down_req,
    input  logic       auto_disable,
    input  logic       enter_compliance,
    input  logic       clk,
    input  logic       rst_n,
    output logic [1:0] sel_speed,
    output logic       retrain_req,
    output logic       compliance_active,
    output logic [1:0] compliance_speed
);
    rate_t common_top;
    rate_t next_sel;

    lss_common_cap u_common (
        .local_vec   (local_speeds),
        .partner_vec (partner_speeds),
        .common_top  (common_top)
    );

    lss_limit_merge u_merge (
        .common_top   (common_top),
        .sw_target    (sw_target),
        .hw_limit     (hw_limit),
        .pm_down_req  (pm_down_req),
        .auto_disable (auto_disable),
        .next_sel     (next_sel)
    );

    lss_sel_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .next_sel  (next_sel),
        .sel_q     (sel_speed),
        .retrain_q (retrain_req)
    );

    lss_compliance u_comp (
        .clk       (clk),
        .rst_n     (rst_n),
        .enter_req (enter_compliance),
        .sw_target (sw_target),
        .active_q  (compliance_active),
        .speed_q   (compliance_speed)
    );
endmodule

// File: rtl/lss_checker.sv
// Property checker for the link speed selector, bound to the top module.
module lss_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] local_speeds,
    input logic [1:0] partner_speeds,
    input logic [1:0] sw_target,
    input logic [1:0] hw_limit,
    input logic       pm_down_req,
    input logic       auto_disable,
    input logic       enter_compliance,
    input logic [1:0] sel_speed,
    input logic       retrain_req,
    input logic       compliance_active,
    input logic [1:0] compliance_speed
);
    logic seen_rst;

    // Marks cycles after at least one reset edge and one live edge.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_rst <= 1'b1;
    end

    logic live;
    // Set once the design has run a full cycle out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) live <= 1'b0;
        else        live <= (seen_rst === 1'b1);
    end

    a_r10_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> $countones(sel_speed) == 1);

    a_r8_pulse_means_change: assert property (@(posedge clk) disable iff (!rst_n)
        (live && retrain_req) |-> sel_speed != $past(sel_speed));

    a_r8_change_means_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (live && sel_speed != $past(sel_speed)) |-> retrain_req);

    a_r2_no_shared_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !(local_speeds[1] && partner_speeds[1])) |=> sel_speed == 2'b01);

    a_r3_sw_cap_slow: assert property (@(posedge clk) disable iff (!rst_n)
        (live && sw_target == 2'b01) |=> sel_speed == 2'b01);

    a_r4_hw_limit_slow: assert property (@(posedge clk) disable iff (!rst_n)
        (live && hw_limit == 2'b01) |=> sel_speed == 2'b01);

    a_r6_pm_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (live && auto_disable && local_speeds[1] && partner_speeds[1]
         && sw_target[1] && hw_limit != 2'b01) |=> sel_speed == 2'b10);

    a_r9_comp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        live |=> compliance_active == $past(enter_compliance));
endmodule

bind link_speed_sel lss_checker u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .local_speeds      (local_speeds),
    .partner_speeds    (partner_speeds),
    .sw_target         (sw_target),
    .hw_limit          (hw_limit),
    .pm_down_req       (pm_down_req),
    .auto_disable      (auto_disable),
    .enter_compliance  (enter_compliance),
    .sel_speed         (sel_speed),
    .retrain_req       (retrain_req),
    .compliance_active (compliance_active),
    .compliance_speed  (compliance_speed)
);

// File: tb/link_speed_sel_bench.sv
// Directed bench for the link speed selector.
module link_speed_sel_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] local_speeds = 2'b11;
    logic [1:0] partner_speeds = 2'b11;
    logic [1:0] sw_target = 2'b10;
    logic [1:0] hw_limit = 2'b00;
    logic       pm_down_req = 1'b0;
    logic       auto_disable = 1'b0;
    logic       enter_compliance = 1'b0;
    logic [1:0] sel_speed;
    logic       retrain_req;
    logic       compliance_active;
    logic [1:0] compliance_speed;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    link_speed_sel u_link_speed_sel (
        .local_speeds      (local_speeds),
        .partner_speeds    (partner_speeds),
        .sw_target         (sw_target),
        .hw_limit          (hw_limit),
        .pm_down_req       (pm_down_req),
        .auto_disable      (auto_disable),
        .enter_compliance  (enter_compliance),
        .clk               (clk),
        .rst_n             (rst_n),
        .sel_speed         (sel_speed),
        .retrain_req       (retrain_req),
        .compliance_active (compliance_active),
        .compliance_speed  (compliance_speed)
    );

    // Records one comparison.
    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive a full input pattern and wait for the registered result.
    task automatic drive(input logic [1:0] lo, input logic [1:0] pa,
                         input logic [1:0] sw, input logic [1:0] hw,
                         input logic pm, input logic ad);
        local_speeds = lo; partner_speeds = pa; sw_target = sw;
        hw_limit = hw; pm_down_req = pm; auto_disable = ad;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R7 reset sel", int'(sel_speed), 1);
        check("R8 reset retrain", int'(retrain_req), 0);
        check("R9 reset comp flag", int'(compliance_active), 0);
        check("R9 reset comp speed", int'(compliance_speed), 1);
    endtask

    task automatic t_common();
        drive(2'b11, 2'b11, 2'b10, 2'b00, 0, 0);
        check("R1 both fast", int'(sel_speed), 2);
        check("R8 pulse on rise", int'(retrain_req), 1);
        drive(2'b11, 2'b11, 2'b10, 2'b00, 0, 0);
        check("R8 pulse single cycle", int'(retrain_req), 0);
        check("R1 held fast", int'(sel_speed), 2);
    endtask

    task automatic t_no_common();
        drive(2'b10, 2'b01, 2'b11, 2'b00, 0, 0);
        check("R2 disjoint", int'(sel_speed), 1);
        check("R8 pulse on fall", int'(retrain_req), 1);
        drive(2'b11, 2'b01, 2'b11, 2'b00, 0, 0);
        check("R2 slow only", int'(sel_speed), 1);
        check("R8 no change no pulse", int'(retrain_req), 0);
        drive(2'b00, 2'b00, 2'b11, 2'b00, 0, 0);
        check("R2 empty vectors", int'(sel_speed), 1);
    endtask

    task automatic t_sw_cap();
        drive(2'b11, 2'b11, 2'b01, 2'b00, 0, 0);
        check("R3 cap slow", int'(sel_speed), 1);
        drive(2'b11, 2'b11, 2'b00, 2'b00, 0, 0);
        check("R3 cap zero", int'(sel_speed), 1);
        drive(2'b11, 2'b11, 2'b11, 2'b00, 0, 0);
        check("R3 cap 11 fast", int'(sel_speed), 2);
    endtask

    task automatic t_hw_limit();
        drive(2'b11, 2'b11, 2'b10, 2'b01, 0, 0);
        check("R4 reliability slow", int'(sel_speed), 1);
        drive(2'b11, 2'b11, 2'b10, 2'b10, 0, 0);
        check("R4 reliability fast", int'(sel_speed), 2);
        drive(2'b11, 2'b11, 2'b10, 2'b00, 0, 0);
        check("R4 no limit", int'(sel_speed), 2);
    endtask

    task automatic t_pm();
        drive(2'b11, 2'b11, 2'b10, 2'b00, 1, 0);
        check("R5 pm downshift", int'(sel_speed), 1);
        check("R8 pulse pm", int'(retrain_req), 1);
        drive(2'b11, 2'b11, 2'b10, 2'b00, 0, 0);
        check("R5 pm released", int'(sel_speed), 2);
    endtask

    task automatic t_auto_dis();
        drive(2'b11, 2'b11, 2'b10, 2'b00, 1, 1);
        check("R6 pm ignored", int'(sel_speed), 2);
        check("R6 no retrain", int'(retrain_req), 0);
        drive(2'b11, 2'b11, 2'b10, 2'b01, 1, 1);
        check("R6 reliability honored", int'(sel_speed), 1);
        drive(2'b11, 2'b11, 2'b10, 2'b00, 0, 1);
        check("R6 back fast", int'(sel_speed), 2);
    endtask

    task automatic t_compliance();
        enter_compliance = 1'b1;
        drive(2'b11, 2'b11, 2'b01, 2'b00, 0, 0);
        check("R9 comp on", int'(compliance_active), 1);
        check("R9 comp speed slow", int'(compliance_speed), 1);
        drive(2'b11, 2'b11, 2'b11, 2'b00, 0, 0);
        check("R9 comp speed fast", int'(compliance_speed), 2);
        check("R1 sel unaffected", int'(sel_speed), 2);
        enter_compliance = 1'b0;
        drive(2'b11, 2'b11, 2'b00, 2'b00, 0, 0);
        check("R9 comp off", int'(compliance_active), 0);
        check("R9 comp speed zero cap", int'(compliance_speed), 1);
    endtask

    // Ends a hung run as a failure.
    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_common();
        t_no_common();
        t_sw_cap();
        t_hw_limit();
        t_pm();
        t_auto_dis();
        t_compliance();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule